// File: doc/BRIEF.md
# Segment Address Translator with Bounds and Rights Checking

This block turns a logical address, given as a segment index plus an offset, into a physical address. The segment descriptors live in an ordinary memory. Two registers locate them: a table origin and a segment count. Both are loaded through a small configuration port.

Each request is accepted while the block is idle. The segment index is first compared with the segment count. An index that is too large traps at once, with no memory traffic. Otherwise the block reads the two descriptor words one after the other. It then checks the descriptor's valid flag, the offset against the segment's limit, and the access type against the rights bits. When every check passes it returns base plus offset. When a check fails it returns a 3-bit cause code instead of an address.

One response comes back for every request. The memory side is a simple read strobe and address. Data is returned with a valid flag, which may arrive in the same cycle as the strobe or in any later cycle.

Top module: `segx_translator`

## Requirements
- R1: A configuration write with `cfg_sel`=0 loads the table origin from `cfg_data`, and with `cfg_sel`=1 loads the segment count from `cfg_data[SEG_W:0]`. Both registers reset to 0, so after reset every request traps with cause 1 until the count is loaded.
- R2: A request whose segment index is greater than or equal to the segment count responds with trap cause 1 in the cycle after it is accepted. It asserts `mem_rd` in no cycle.
- R3: For any other request, the block reads word 0 at origin + 2·index, and then word 1 at origin + 2·index + 1. Each word is held until `mem_rvalid`.
- R4: Word 0 bits [ADDR_W-1:0] hold the segment base. Word 1 bits [OFF_W-1:0] hold the limit. The rights bits of word 1 are: bit OFF_W = present, OFF_W+1 = writable, OFF_W+2 = execute-only, OFF_W+3 = supervisor-only.
- R5: A descriptor whose present bit is 0 traps with cause 2.
- R6: An offset greater than or equal to the limit traps with cause 3. Legal offsets are 0 to limit-1, so a limit of 0 makes every offset trap.
- R7: Access codes are 0 = read, 1 = write, 2 = fetch (3 is handled as read). A request traps with cause 4 in three cases: a write to a segment that is not writable; a read or write to an execute-only segment; or a request with `req_priv`=0 to a supervisor-only segment.
- R8: When several descriptor checks fail, the reported cause follows this order: cause 2 first, then cause 3, then cause 4.
- R9: When no check fails, the response has `rsp_trap`=0, `rsp_cause`=0 and `rsp_paddr` = base + offset modulo 2^ADDR_W. On a trap, `rsp_trap`=1 and `rsp_paddr`=0.
- R10: `req_ready` is high only while idle. Each accepted request yields exactly one `rsp_valid` pulse of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = table origin, 1 = segment count |
| cfg_data | input | ADDR_W | Configuration write data |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and accepting a request |
| req_seg | input | SEG_W | Segment index |
| req_off | input | OFF_W | Offset within the segment |
| req_acc | input | 2 | Access type code |
| req_priv | input | 1 | 1 = supervisor request |
| mem_rd | output | 1 | Descriptor read strobe |
| mem_addr | output | ADDR_W | Descriptor word address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DATA_W | Read data |
| rsp_valid | output | 1 | Response pulse |
| rsp_trap | output | 1 | 1 = request trapped |
| rsp_cause | output | 3 | Trap cause code, 0 when no trap |
| rsp_paddr | output | ADDR_W | Translated physical address |

## Verification
The assertions assume three things about the inputs. The configuration registers are written only while `req_ready` is high. The memory raises `mem_rvalid` only while `mem_rd` is high. Requests are presented while idle. The stimulus writes the origin and count only before a request is issued or between responses. Its memory model answers in the same cycle as the strobe. It lowers `req_valid` right after the accepting edge, so no translation ever sees its configuration change midway.

// File: rtl/segx_pkg.sv
package segx_pkg;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_FETCH = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_t;

   typedef enum logic [2:0] {
      CAUSE_NONE    = 3'd0,
      CAUSE_RANGE   = 3'd1,
      CAUSE_INVALID = 3'd2,
      CAUSE_LIMIT   = 3'd3,
      CAUSE_PROT    = 3'd4
   } cause_t;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_WORD0,
      ST_WORD1,
      ST_RESP
   } st_t;

   typedef struct packed {
      logic sup_only;
      logic x_only;
      logic wr_ok;
      logic present;
   } rights_t;

endpackage

// File: rtl/segx_range_chk.sv
module segx_range_chk #(
   parameter int SEG_W = 8
) (
   input  logic [SEG_W-1:0] seg,
   input  logic [SEG_W:0]   count,
   output logic             in_range
);
   localparam int CW = SEG_W + 1;

   if (SEG_W < 1) begin : g_bad_seg_w
      $error("segx_range_chk: SEG_W must be at least 1");
   end

   assign in_range = CW'(seg) < count;
endmodule

// File: rtl/segx_rights_chk.sv
module segx_rights_chk
   import segx_pkg::*;
(
   input  rights_t    rights,
   input  logic [1:0] acc,
   input  logic       priv,
   output logic       deny
);
   logic is_write, is_fetch, is_data;

   always_comb begin
      is_write = (acc == ACC_WRITE);
      is_fetch = (acc == ACC_FETCH);
      is_data  = !is_fetch;
      deny     = (is_write && !rights.wr_ok)
              || (is_data && rights.x_only)
              || (rights.sup_only && !priv);
   end
endmodule

// File: rtl/segx_desc_eval.sv
module segx_desc_eval
   import segx_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int DATA_W = 24,
   parameter int OFF_W  = 20
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [DATA_W-1:0] word1,
   input  logic [OFF_W-1:0]  off,
   input  logic [1:0]        acc,
   input  logic              priv,
   output logic [2:0]        cause,
   output logic [ADDR_W-1:0] paddr
);
   localparam int RB = $bits(rights_t);

   if (DATA_W < OFF_W + RB) begin : g_bad_word
      $error("segx_desc_eval: DATA_W too small for limit and rights");
   end
   if (ADDR_W < OFF_W) begin : g_bad_addr
      $error("segx_desc_eval: ADDR_W must cover OFF_W");
   end

   logic [OFF_W-1:0] limit;
   rights_t          rights;
   logic             deny;

   assign limit  = word1[OFF_W-1:0];
   assign rights = rights_t'(word1[OFF_W +: RB]);

   segx_rights_chk u_rights (
      .rights (rights),
      .acc    (acc),
      .priv   (priv),
      .deny   (deny)
   );

   always_comb begin
      if (!rights.present)    cause = CAUSE_INVALID;
      else if (off >= limit)  cause = CAUSE_LIMIT;
      else if (deny)          cause = CAUSE_PROT;
      else                    cause = CAUSE_NONE;
      paddr = base + ADDR_W'(off);
   end
endmodule

// File: rtl/segx_translator.sv
module segx_translator
   import segx_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int DATA_W = 24,
   parameter int SEG_W  = 8,
   parameter int OFF_W  = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_sel,
   input  logic [ADDR_W-1:0] cfg_data,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [SEG_W-1:0]  req_seg,
   input  logic [OFF_W-1:0]  req_off,
   input  logic [1:0]        req_acc,
   input  logic              req_priv,
   output logic              mem_rd,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_rvalid,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              rsp_valid,
   output logic              rsp_trap,
   output logic [2:0]        rsp_cause,
   output logic [ADDR_W-1:0] rsp_paddr
);
   localparam int CW = SEG_W + 1;

   if (ADDR_W < CW + 1) begin : g_bad_cfg
      $error("segx_translator: ADDR_W must exceed SEG_W + 1");
   end
   if (DATA_W < ADDR_W) begin : g_bad_base
      $error("segx_translator: DATA_W must hold a full base");
   end

   st_t               state;
   logic [ADDR_W-1:0] tbl_org;
   logic [CW-1:0]     seg_cnt;
   logic [SEG_W-1:0]  seg_q;
   logic [OFF_W-1:0]  off_q;
   logic [1:0]        acc_q;
   logic              priv_q;
   logic [ADDR_W-1:0] base_q;
   logic              in_range;
   logic [2:0]        ev_cause;
   logic [ADDR_W-1:0] ev_paddr;
   logic [ADDR_W-1:0] desc_addr;

   segx_range_chk #(.SEG_W(SEG_W)) u_range (
      .seg      (req_seg),
      .count    (seg_cnt),
      .in_range (in_range)
   );

   segx_desc_eval #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W)) u_eval (
      .base  (base_q),
      .word1 (mem_rdata),
      .off   (off_q),
      .acc   (acc_q),
      .priv  (priv_q),
      .cause (ev_cause),
      .paddr (ev_paddr)
   );

   assign desc_addr = tbl_org + (ADDR_W'(seg_q) << 1);
   assign mem_rd    = (state == ST_WORD0) || (state == ST_WORD1);
   assign mem_addr  = (state == ST_WORD1) ? desc_addr + ADDR_W'(1) : desc_addr;
   assign req_ready = (state == ST_IDLE);
   assign rsp_valid = (state == ST_RESP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         tbl_org   <= '0;
         seg_cnt   <= '0;
         seg_q     <= '0;
         off_q     <= '0;
         acc_q     <= '0;
         priv_q    <= 1'b0;
         base_q    <= '0;
         rsp_trap  <= 1'b0;
         rsp_cause <= CAUSE_NONE;
         rsp_paddr <= '0;
      end else begin
         if (cfg_we) begin
            if (!cfg_sel) tbl_org <= cfg_data;
            else          seg_cnt <= cfg_data[CW-1:0];
         end
         unique case (state)
            ST_IDLE: if (req_valid) begin
               seg_q  <= req_seg;
               off_q  <= req_off;
               acc_q  <= req_acc;
               priv_q <= req_priv;
               if (in_range) begin
                  state <= ST_WORD0;
               end else begin
                  rsp_trap  <= 1'b1;
                  rsp_cause <= CAUSE_RANGE;
                  rsp_paddr <= '0;
                  state     <= ST_RESP;
               end
            end
            ST_WORD0: if (mem_rvalid) begin
               base_q <= mem_rdata[ADDR_W-1:0];
               state  <= ST_WORD1;
            end
            ST_WORD1: if (mem_rvalid) begin
               rsp_cause <= ev_cause;
               rsp_trap  <= (ev_cause != CAUSE_NONE);
               rsp_paddr <= (ev_cause == CAUSE_NONE) ? ev_paddr : '0;
               state     <= ST_RESP;
            end
            ST_RESP: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   // An out-of-range index reaches the response with no table read
   assert_range_trap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready && req_valid && (CW'(req_seg) >= seg_cnt))
      |=> (rsp_valid && rsp_cause == CAUSE_RANGE && !mem_rd));

   // The second descriptor word directly follows the first
   assert_word_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WORD1 && $past(state) == ST_WORD0)
      |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

   // Configuration is only changed while idle (input assumption)
   assert_cfg_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |-> req_ready);

   // Trap flag and cause code agree; a trap carries no address
   assert_trap_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> ((rsp_trap == (rsp_cause != CAUSE_NONE))
                     && (!rsp_trap || rsp_paddr == '0)));

   // Responses are single-cycle pulses
   assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
endmodule

// File: tb/segx_translator_bench.sv
module segx_translator_bench;
   localparam int AW = 24, DW = 24, SW = 8, OW = 20;
   localparam int ORG = 8;
   localparam int NV = 13;
   // {seg, off, acc, priv, cause, paddr}
   localparam logic [57:0] VEC [NV] = '{
      {8'd2, 20'd399,  2'd0, 1'b0, 3'd0, 24'd4699},  // R9
      {8'd4, 20'd0,    2'd0, 1'b1, 3'd0, 24'd4700},  // R9
      {8'd4, 20'd1000, 2'd0, 1'b1, 3'd3, 24'd0},     // R6
      {8'd3, 20'd1300, 2'd2, 1'b0, 3'd3, 24'd0},     // R6
      {8'd6, 20'd297,  2'd0, 1'b0, 3'd1, 24'd0},     // R2
      {8'd2, 20'd10,   2'd1, 1'b0, 3'd4, 24'd0},     // R7 write read-only
      {8'd3, 20'd5,    2'd0, 1'b0, 3'd4, 24'd0},     // R7 read exec-only
      {8'd3, 20'd5,    2'd2, 1'b0, 3'd0, 24'd3205},  // R7 fetch ok
      {8'd4, 20'd5,    2'd0, 1'b0, 3'd4, 24'd0},     // R7 user on supervisor
      {8'd0, 20'd999,  2'd1, 1'b0, 3'd0, 24'd2399},  // R6 last legal
      {8'd4, 20'd1000, 2'd0, 1'b0, 3'd3, 24'd0},     // R8 limit over prot
      {8'd5, 20'd0,    2'd0, 1'b0, 3'd1, 24'd0},     // R2 index == count
      {8'd1, 20'd399,  2'd1, 1'b0, 3'd0, 24'd6699}   // R9
   };

   logic clk = 0, rst_n = 0;
   logic cfg_we = 0, cfg_sel = 0;
   logic [AW-1:0] cfg_data = '0;
   logic req_valid = 0, req_ready, req_priv = 0;
   logic [SW-1:0] req_seg = '0;
   logic [OW-1:0] req_off = '0;
   logic [1:0] req_acc = '0;
   logic mem_rd, mem_rvalid;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_rdata;
   logic rsp_valid, rsp_trap;
   logic [2:0] rsp_cause;
   logic [AW-1:0] rsp_paddr;

   logic [DW-1:0] mem [64];
   int n_rd = 0;
   logic [AW-1:0] rd_log [8];
   int checks = 0, errors = 0;
   bit done = 0;
   int lat;
   logic got_trap;
   logic [2:0] got_cause;
   logic [AW-1:0] got_paddr;

   always #5 clk = ~clk;

   assign mem_rvalid = mem_rd;
   assign mem_rdata  = mem[mem_addr[5:0]];

   always @(posedge clk) if (mem_rd) begin
      rd_log[n_rd[2:0]] <= mem_addr;
      n_rd <= n_rd + 1;
   end

   segx_translator #(.ADDR_W(AW), .DATA_W(DW), .SEG_W(SW), .OFF_W(OW)) u_segx_translator (
      .clk, .rst_n, .cfg_we, .cfg_sel, .cfg_data, .req_valid, .req_ready,
      .req_seg, .req_off, .req_acc, .req_priv, .mem_rd, .mem_addr,
      .mem_rvalid, .mem_rdata, .rsp_valid, .rsp_trap, .rsp_cause, .rsp_paddr);

   function automatic logic [DW-1:0] w1(input int limit, input logic [3:0] r);
      return {r, limit[OW-1:0]};
   endfunction

   task automatic put_desc(input int s, input int base, input int limit, input logic [3:0] r);
      mem[ORG + 2*s]     = base[DW-1:0];
      mem[ORG + 2*s + 1] = w1(limit, r);
   endtask

   task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   task automatic cfg(input logic sel, input int val);
      @(negedge clk);
      cfg_we = 1; cfg_sel = sel; cfg_data = val[AW-1:0];
      @(negedge clk);
      cfg_we = 0;
   endtask

   task automatic xlate(input int s, input int off, input int acc, input logic pv);
      @(negedge clk);
      req_valid = 1; req_seg = s[SW-1:0]; req_off = off[OW-1:0];
      req_acc = acc[1:0]; req_priv = pv;
      @(posedge clk);
      #1 req_valid = 0;
      lat = 0;
      do begin
         @(negedge clk);
         lat++;
      end while (!rsp_valid && lat < 20);
      got_trap = rsp_trap; got_cause = rsp_cause; got_paddr = rsp_paddr;
      @(negedge clk);
      chk(!rsp_valid && req_ready, "R10 pulse then idle", rsp_valid, 0);
   endtask

   initial begin
      int base0;
      foreach (mem[i]) mem[i] = '0;
      // rights: 1 present, 2 writable, 4 exec-only, 8 supervisor-only
      put_desc(0, 1400, 1000, 4'h3);
      put_desc(1, 6300, 400,  4'h3);
      put_desc(2, 4300, 400,  4'h1);
      put_desc(3, 3200, 1100, 4'h5);
      put_desc(4, 4700, 1000, 4'hB);
      put_desc(5, 100,  100,  4'h2);       // not present
      put_desc(6, 200,  0,    4'h3);       // zero limit
      put_desc(7, 24'hFFFFF0, 24'h100, 4'h3);
      repeat (3) @(negedge clk);
      chk(!rsp_valid && req_ready && !mem_rd, "R10 reset state", rsp_valid, 0);
      rst_n = 1;

      // R1: count resets to zero, so index 0 traps
      xlate(0, 0, 0, 1);
      chk(got_cause == 3'd1 && got_trap, "R1 zero count traps", got_cause, 1);

      cfg(0, ORG);
      cfg(1, 5);

      for (int i = 0; i < NV; i++) begin
         logic [57:0] v;
         v = VEC[i];
         base0 = n_rd;
         xlate(int'(v[57:50]), int'(v[49:30]), int'(v[29:28]), v[27]);
         chk(got_cause == v[26:24] && got_trap == (v[26:24] != 0), "R5-R9 vector cause",
             got_cause, v[26:24]);
         chk(got_paddr == v[23:0], "R9 vector paddr", got_paddr, v[23:0]);
         if (v[26:24] == 3'd1) begin
            chk(n_rd == base0, "R2 no memory read", n_rd - base0, 0);
            chk(lat == 1, "R2 latency", lat, 1);
         end
      end

      // R3: read order for index 2
      base0 = n_rd;
      xlate(2, 1, 0, 0);
      chk(n_rd - base0 == 2, "R3 two reads", n_rd - base0, 2);
      chk(rd_log[base0[2:0]] == AW'(ORG + 4), "R3 first word addr", rd_log[base0[2:0]], ORG + 4);
      chk(rd_log[base0[2:0] + 3'd1] == AW'(ORG + 5), "R3 second word addr",
          rd_log[base0[2:0] + 3'd1], ORG + 5);

      cfg(1, 8);
      // R5 and R8: not present wins over limit and write rights
      xlate(5, 500, 1, 0);
      chk(got_cause == 3'd2, "R5 R8 invalid descriptor", got_cause, 2);
      // R6: zero limit traps at offset 0
      xlate(6, 0, 0, 1);
      chk(got_cause == 3'd3, "R6 zero limit", got_cause, 3);
      // R9: address wraps modulo 2^ADDR_W
      xlate(7, 32, 1, 0);
      chk(got_cause == 0 && got_paddr == 24'h10, "R9 wrap", got_paddr, 24'h10);
      // R4: origin change moves the descriptor read
      cfg(0, ORG + 2);
      xlate(0, 50, 0, 0);
      chk(got_cause == 0 && got_paddr == 24'd6350, "R4 R1 origin reload", got_paddr, 6350);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule